// File: doc/BRIEF.md
# SPI Byte Transceiver Register

This block is a single read/write register that a small processor uses to talk to an SPI slave, such as a serial flash, in mode 0 (clock idles low, data captured on the rising clock edge). A write carries a command flag and a data byte. When the flag is clear, the write starts a full-duplex exchange of that byte and pulls chip select low. When the flag is set, the write only releases chip select.

Each exchange lasts sixteen system clocks and produces eight serial clock pulses. The serial clock is decoded from an internal step counter, so no separate clock divider is needed. Chip select is a level that software controls. It stays low across as many bytes as software sends, so a multi-byte command frame is built one write at a time. A read returns a busy flag in the top bit and the shift register contents in the low byte. Once the busy flag clears, the low byte holds the byte that came in from the slave.

Top module: `spi_byte_xcvr`

## Requirements
- R1: A write (`load`=1) with `wr_data[8]`=0 drives `spi_cs_n` low from the next cycle. `spi_cs_n` stays low after the byte completes and until a release write arrives.
- R2: A write with `wr_data[8]`=1 drives `spi_cs_n` high from the next cycle. If the block is idle, this write starts no transfer: `rd_data[15]` and `spi_sck` stay 0.
- R3: A starting write makes `rd_data[15]` read 1 for exactly the 16 cycles that follow it. `rd_data[15]` then reads 0.
- R4: Number the cycles after a starting write 1 to 16. `spi_sck` is high in the even-numbered cycles and low in the odd ones and whenever the block is idle, which gives 8 pulses per byte.
- R5: `spi_mosi` presents `wr_data[7:0]` most significant bit first. Bit 7-k is shown in cycles 2k+1 and 2k+2, so the line changes only on the edge where `spi_sck` falls.
- R6: `spi_miso` is registered on every clock. The value driven in cycle 2k+1 becomes bit 7-k of the received byte. After the transfer, `rd_data[7:0]` holds the received byte.
- R7: Any write, whatever its flag, loads `wr_data[7:0]` into the shift register. A release write can therefore be read back in `rd_data[7:0]`, and its bit 7 appears on `spi_mosi`.
- R8: A starting write that arrives during a transfer restarts the exchange with the new byte. The block then runs a full 16 cycles counted from that write.
- R9: After a synchronous reset `spi_cs_n` is 1 and `rd_data`, `spi_sck` and `spi_mosi` are 0. `rd_data[14:8]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Register write strobe |
| wr_data | input | 16 | Write word: bit 8 is the release flag, bits 7:0 are the byte to send |
| rd_data | output | 16 | Read word: bit 15 is busy, bits 7:0 are the shift register / received byte |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
If the step counter is off by one, the busy bit drops one cycle early or late, and the serial clock pulses shift into the wrong phase. Both show up at the ports within the first two cycles of a transfer. A shift register that shifts on the wrong phase puts the wrong bit on `spi_mosi` by cycle 3, and it corrupts the received byte, which is visible as soon as busy clears. A chip-select register that is not held keeps the wrong level until the next write, so the bench samples `spi_cs_n` after each write and again after each transfer ends.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

    localparam int XCVR_WORD_W = 16;
    localparam int XCVR_DATA_W = 8;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_START   = 2'd1,
        CMD_RELEASE = 2'd2
    } wr_cmd_e;

    function automatic wr_cmd_e decode_cmd(input logic strobe, input logic release_flag);
        if (!strobe)
            return CMD_IDLE;
        else if (release_flag)
            return CMD_RELEASE;
        else
            return CMD_START;
    endfunction

endpackage

// File: rtl/spi_step_counter.sv
module spi_step_counter #(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic busy,
    output logic sck
);
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS);

    logic [CNT_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst)
            step_q <= '0;
        else if (restart)
            step_q <= CNT_W'(1);
        else if (step_q == LAST)
            step_q <= '0;
        else if (step_q != '0)
            step_q <= step_q + CNT_W'(1);
    end

    assign busy = (step_q != '0);
    assign sck  = busy & ~step_q[0];

    // R3
    restart_begins_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (busy && !sck));

    // R3
    busy_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q == LAST && !restart) |=> !busy);

    // R4
    sck_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sck |=> !sck);

endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              shift_en,
    input  logic              miso,
    output logic [DATA_W-1:0] q
);
    logic miso_q;

    always_ff @(posedge clk) begin
        if (rst)
            miso_q <= 1'b0;
        else
            miso_q <= miso;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
        else if (shift_en)
            q <= {q[DATA_W-2:0], miso_q};
    end

    // R7
    load_takes_byte_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din)));

    // R6
    shift_inserts_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && shift_en) |=> (q[0] == $past(miso_q)) && (q[DATA_W-1:1] == $past(q[DATA_W-2:0])));

    // R5
    hold_when_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift_en) |=> $stable(q));

endmodule

// File: rtl/spi_select_reg.sv
module spi_select_reg (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic release_flag,
    output logic cs_n
);
    always_ff @(posedge clk) begin
        if (rst)
            cs_n <= 1'b1;
        else if (load)
            cs_n <= release_flag;
    end

    // R1
    select_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cs_n == $past(release_flag)));

    // R1
    select_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cs_n));

endmodule

// File: rtl/spi_byte_xcvr.sv
module spi_byte_xcvr
    import spi_xcvr_pkg::*;
#(
    parameter int WORD_W = XCVR_WORD_W,
    parameter int DATA_W = XCVR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    output logic              spi_sck,
    input  logic              spi_miso
);
    localparam int SEL_BIT = DATA_W;
    localparam int STEPS   = 2 * DATA_W;
    localparam int PAD_W   = WORD_W - 1 - DATA_W;

    wr_cmd_e           cmd;
    logic              busy;
    logic [DATA_W-1:0] shreg;

    assign cmd = decode_cmd(load, wr_data[SEL_BIT]);

    spi_step_counter #(.STEPS(STEPS)) u_steps (
        .clk     (clk),
        .rst     (rst),
        .restart (cmd == CMD_START),
        .busy    (busy),
        .sck     (spi_sck)
    );

    spi_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .din      (wr_data[DATA_W-1:0]),
        .shift_en (spi_sck),
        .miso     (spi_miso),
        .q        (shreg)
    );

    spi_select_reg u_select (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .release_flag (wr_data[SEL_BIT]),
        .cs_n         (spi_cs_n)
    );

    assign spi_mosi = shreg[DATA_W-1];
    assign rd_data  = {busy, {PAD_W{1'b0}}, shreg};

    // R2
    release_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RELEASE && !busy) |=> (!busy && !spi_sck));

    // R8
    restart_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_START && busy) |=> (rd_data[WORD_W-1] && !spi_sck && spi_mosi == $past(wr_data[DATA_W-1])));

endmodule

// File: tb/spi_byte_xcvr_test.sv
`timescale 1ns/1ps
module spi_byte_xcvr_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        spi_cs_n, spi_mosi, spi_sck;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // {byte sent, byte returned by slave}
    localparam logic [15:0] VECS [5] = '{16'hA53C, 16'hFF00, 16'h0181, 16'h6E97, 16'h00FF};

    spi_byte_xcvr uut (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .spi_cs_n (spi_cs_n),
        .spi_mosi (spi_mosi),
        .spi_sck  (spi_sck),
        .spi_miso (spi_miso)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [15:0] w);
        @(negedge clk);
        load    = 1'b1;
        wr_data = w;
        @(negedge clk);
        load    = 1'b0;
        wr_data = '0;
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] rx);
        do_write({8'h00, tx});
        for (int c = 1; c <= 16; c++) begin
            int idx = 7 - (c - 1) / 2;
            spi_miso = rx[idx];
            chk(rd_data[15] == 1'b1, "R3 busy", 16'(rd_data[15]), 16'd1);
            chk(spi_sck == (c % 2 == 0), "R4 sck", 16'(spi_sck), 16'(c % 2 == 0));
            chk(spi_mosi == tx[idx], "R5 mosi", 16'(spi_mosi), 16'(tx[idx]));
            chk(spi_cs_n == 1'b0, "R1 cs low", 16'(spi_cs_n), 16'd0);
            chk(rd_data[14:8] == 7'd0, "R9 pad", 16'(rd_data[14:8]), 16'd0);
            @(negedge clk);
        end
        chk(rd_data == {8'h00, rx}, "R6 rx byte", rd_data, {8'h00, rx});
        chk(spi_sck == 1'b0, "R4 idle sck", 16'(spi_sck), 16'd0);
        chk(spi_cs_n == 1'b0, "R1 cs held", 16'(spi_cs_n), 16'd0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(spi_cs_n == 1'b1, "R9 cs", 16'(spi_cs_n), 16'd1);
        chk(rd_data == 16'h0000, "R9 rd", rd_data, 16'h0000);
        chk(spi_sck == 1'b0, "R9 sck", 16'(spi_sck), 16'd0);
        chk(spi_mosi == 1'b0, "R9 mosi", 16'(spi_mosi), 16'd0);
        rst = 1'b0;

        foreach (VECS[i]) xfer(VECS[i][15:8], VECS[i][7:0]);

        // R1: select stays low while idle
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b0, "R1 cs idle low", 16'(spi_cs_n), 16'd0);
        chk(rd_data == 16'h00FF, "R6 rx held", rd_data, 16'h00FF);

        // R8: restart during a transfer
        do_write(16'h0055);
        repeat (4) @(negedge clk);
        xfer(8'hC3, 8'h5A);

        // R2 / R7: release write
        do_write(16'h01A5);
        chk(spi_cs_n == 1'b1, "R2 cs high", 16'(spi_cs_n), 16'd1);
        chk(rd_data == 16'h00A5, "R7 release loads", rd_data, 16'h00A5);
        chk(spi_mosi == 1'b1, "R7 mosi bit7", 16'(spi_mosi), 16'd1);
        for (int k = 0; k < 4; k++) begin
            chk(spi_sck == 1'b0, "R2 no sck", 16'(spi_sck), 16'd0);
            chk(rd_data[15] == 1'b0, "R2 not busy", 16'(rd_data[15]), 16'd0);
            @(negedge clk);
        end
        chk(spi_cs_n == 1'b1, "R2 cs stays high", 16'(spi_cs_n), 16'd1);

        // R1: a new start after release pulls select low again
        xfer(8'h3C, 8'hE1);

        // R9: reset mid-transfer returns to idle
        do_write(16'h00F0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R9 reset cs", 16'(spi_cs_n), 16'd1);
        chk(rd_data == 16'h0000, "R9 reset rd", rd_data, 16'h0000);
        chk(spi_sck == 1'b0, "R9 reset sck", 16'(spi_sck), 16'd0);
        rst = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule